// File: doc/BRIEF.md
# Masked Priority Interrupt Request Unit

This unit gathers up to eight interrupt request lines from peripherals and decides which one the processor core is asked to service next. Line 0 is reserved and never produces a request. The other lines are the receive buffer holding data (1), the receive buffer being full (2), the transmit buffer holding data (3), the transmit buffer being full (4), a fresh keyboard character (5), the timer (6) and a push-button change (7). Software writes an enable mask through the low byte of an I/O word. Each enabled line that rises sets a single pending bit.

Pending requests are presented to the core one at a time as a vector number, and only while the core's global interrupt enable is high. The core uses that number directly as its call address. When several requests are waiting, the lowest number is presented first. The core takes a request by pulsing an acknowledge while the vector is valid. This clears that pending bit, and in the same edge the next waiting vector, if there is one, is put on the outputs. A line that rises again while its earlier request is still pending is lost, not counted.

Top module: `intr_mask_prio`

## Requirements
- R1: After reset `irq_valid_o` is 0, `irq_vec_o` is 0, the mask is all zeros and no request is pending. A rising line with no mask write after reset is never presented.
- R2: A cycle with `mask_wr_i` high loads `mask_data_i[7:0]` into the mask. Bit n set to 1 enables line n. Bits 15:8 are ignored, so a write of 16'hFF00 enables nothing.
- R3: Only a 0-to-1 transition on a line sets its pending bit. A line held high after its request is acknowledged does not request again.
- R4: A rising edge on a line whose mask bit is 0 when the edge is detected is discarded. Setting the mask bit later does not recover it.
- R5: Take a line that is enabled, with the global enable high and nothing else pending. If the line rises before clock edge k, `irq_valid_o` is 0 after edges k and k+1 and is 1 after edge k+2.
- R6: `irq_vec_o` carries the number of the presented line as a 3-bit binary value, which is the call address.
- R7: When several enabled requests are pending, the one with the lowest number is presented first. The rest follow in ascending order as each is acknowledged.
- R8: With `core_ie_i` low, `irq_valid_o` goes to 0 after the next edge, but pending bits are kept. When `core_ie_i` returns high, the held request is presented after the next edge.
- R9: A second rising edge on a line whose request is still pending is dropped. Exactly one delivery results.
- R10: `irq_ack_i` high at an edge while `irq_valid_o` is 1 clears the pending bit of the presented vector. In that same edge the outputs move to the next pending vector, or `irq_valid_o` goes to 0 if none remains.
- R11: Line 0 never produces a request, whatever its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 8 | Interrupt request lines, line n on bit n |
| mask_wr_i | input | 1 | Mask register write strobe |
| mask_data_i | input | 16 | I/O write word; bits 7:0 are the mask |
| core_ie_i | input | 1 | Core global interrupt enable |
| irq_ack_i | input | 1 | Core acknowledges the presented vector |
| irq_valid_o | output | 1 | A vector is being presented |
| irq_vec_o | output | 3 | Presented vector number (call address) |

## Verification
The assertions check the following on every cycle:
- A presented vector is never 0.
- A presented vector was pending and unmasked one cycle earlier.
- Nothing is presented without the global enable.
- An acknowledge clears the taken bit.
- A pending bit is never lost without being acknowledged.
- A masked line never becomes pending.

Some behaviours can only be shown by the bench scenarios:
- The exact three-edge latency.
- Ascending delivery order for every one of the 256 mask values.
- Edge-only triggering when a line is held high.
- Loss of a repeated request.
- Ignored upper mask bits.
- Permanent loss of an edge that arrives while its line is masked.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned DEF_NUM_SRC = 8;
  localparam int unsigned DEF_WORD_W  = 16;
endpackage

// File: rtl/intr_edge_sync.sv
module intr_edge_sync #(
  parameter int unsigned NUM_SRC = intr_pkg::DEF_NUM_SRC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] rise_o
);
  logic [NUM_SRC-1:0] smp_q, smp_d;
  logic [NUM_SRC-1:0] prv_q, prv_d;

  always_comb begin
    smp_d = src_i;
    prv_d = smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q <= '0;
      prv_q <= '0;
    end else begin
      smp_q <= smp_d;
      prv_q <= prv_d;
    end
  end

  assign rise_o = smp_q & ~prv_q;
endmodule

// File: rtl/intr_pend_bank.sv
module intr_pend_bank #(
  parameter int unsigned NUM_SRC = intr_pkg::DEF_NUM_SRC,
  parameter int unsigned WORD_W  = intr_pkg::DEF_WORD_W,
  parameter bit          RSVD_ZERO = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_wr_i,
  input  logic [WORD_W-1:0]  mask_data_i,
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic               unused_hi;

  assign unused_hi = ^mask_data_i[WORD_W-1:NUM_SRC];

  always_comb begin
    mask_d = mask_q;
    if (mask_wr_i) mask_d = mask_data_i[NUM_SRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    if (RSVD_ZERO && i == 0) begin : g_rsvd
      assign pend_d[i] = 1'b0;
    end else begin : g_live
      assign pend_d[i] = (pend_q[i] & ~clr_i[i]) | (rise_i[i] & mask_q[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= pend_d[i];
    end

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q[i] && !clr_i[i]) |=> pend_q[i]) else $error("pending lost"); // R9
    AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q[i] && !mask_q[i]) |=> !pend_q[i]) else $error("masked set"); // R4
  end

  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i)) else $error("multi clear"); // R10

  assign mask_o = mask_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int unsigned NUM_SRC = intr_pkg::DEF_NUM_SRC,
  localparam int unsigned VEC_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] elig_i,
  output logic               any_o,
  output logic [VEC_W-1:0]   idx_o
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] pick;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign pick[i]   = elig_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig_i[i];
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pick[i]) idx_o = idx_o | VEC_W'(i);
    end
  end

  assign any_o = seen[NUM_SRC];
endmodule

// File: rtl/intr_mask_prio.sv
module intr_mask_prio #(
  parameter int unsigned NUM_SRC = intr_pkg::DEF_NUM_SRC,
  parameter int unsigned WORD_W  = intr_pkg::DEF_WORD_W,
  localparam int unsigned VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               mask_wr_i,
  input  logic [WORD_W-1:0]  mask_data_i,
  input  logic               core_ie_i,
  input  logic               irq_ack_i,
  output logic               irq_valid_o,
  output logic [VEC_W-1:0]   irq_vec_o
);
  logic [NUM_SRC-1:0] rise_w, mask_w, pend_w, clr_w, elig_w;
  logic               any_w;
  logic [VEC_W-1:0]   idx_w;
  logic               vld_q, vld_d;
  logic [VEC_W-1:0]   vec_q, vec_d;
  logic               take_w;

  intr_edge_sync #(.NUM_SRC(NUM_SRC)) sync_i (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .rise_o(rise_w));

  intr_pend_bank #(.NUM_SRC(NUM_SRC), .WORD_W(WORD_W), .RSVD_ZERO(1'b1)) bank_i (
    .clk(clk), .rst_n(rst_n), .mask_wr_i(mask_wr_i), .mask_data_i(mask_data_i),
    .rise_i(rise_w), .clr_i(clr_w), .mask_o(mask_w), .pend_o(pend_w));

  assign take_w = irq_ack_i & vld_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_w[i] = take_w & (vec_q == VEC_W'(i));
  end

  assign elig_w = pend_w & ~clr_w & mask_w & {NUM_SRC{core_ie_i}};

  intr_prio_pick #(.NUM_SRC(NUM_SRC)) pick_i (
    .elig_i(elig_w), .any_o(any_w), .idx_o(idx_w));

  always_comb begin
    vld_d = any_w;
    vec_d = any_w ? idx_w : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= vld_d;
      vec_q <= vec_d;
    end
  end

  assign irq_valid_o = vld_q;
  assign irq_vec_o   = vec_q;

  AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_vec_o != '0)) else $error("vector zero"); // R11
  AST_VALID_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> $past(core_ie_i)) else $error("no enable"); // R8
  AST_VALID_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> |($past(pend_w) & (NUM_SRC'(1) << irq_vec_o))) else $error("not pending"); // R6
  AST_VALID_WAS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> |($past(mask_w) & (NUM_SRC'(1) << irq_vec_o))) else $error("masked"); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack_i && irq_valid_o && !(|(rise_w & (NUM_SRC'(1) << irq_vec_o))))
      |=> !(|(pend_w & (NUM_SRC'(1) << $past(irq_vec_o))))) else $error("ack kept"); // R10
endmodule

// File: tb/intr_mask_prio_tb.sv
`timescale 1ns/1ps
module intr_mask_prio_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  src;
  logic        mask_wr;
  logic [15:0] mask_data;
  logic        ie;
  logic        ack;
  logic        valid;
  logic [2:0]  vec;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  intr_mask_prio dut_i (
    .clk(clk), .rst_n(rst_n), .src_i(src), .mask_wr_i(mask_wr),
    .mask_data_i(mask_data), .core_ie_i(ie), .irq_ack_i(ack),
    .irq_valid_o(valid), .irq_vec_o(vec));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mask(input logic [15:0] v);
    mask_wr = 1'b1; mask_data = v;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic settle();
    src = '0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; src = '0; mask_wr = 1'b0; mask_data = '0; ie = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(vec == 3'd0, "R1 vec", vec, 0);
    ie = 1'b1;
    src = 8'h08;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0, "R1 mask clear", valid, 0);
    settle();

    // R2: upper bits ignored
    wr_mask(16'hFF00);
    src = 8'hFE;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0, "R2 upper bits", valid, 0);
    settle();

    // R5/R6/R11/R3 single line sweep
    wr_mask(16'h00FF);
    for (int i = 0; i < 8; i++) begin
      src = 8'(1 << i);
      @(negedge clk);
      chk(valid == 1'b0, "R5 edge k", valid, 0);
      @(negedge clk);
      chk(valid == 1'b0, "R5 edge k+1", valid, 0);
      @(negedge clk);
      if (i == 0) begin
        chk(valid == 1'b0, "R11 line0", valid, 0);
      end else begin
        chk(valid == 1'b1, "R5 edge k+2", valid, 1);
        chk(vec == 3'(i), "R6 vector", vec, i);
        pulse_ack();
        chk(valid == 1'b0, "R10 cleared", valid, 0);
      end
      repeat (3) @(negedge clk);
      chk(valid == 1'b0, "R3 level held", valid, 0);
      settle();
    end

    // R7: every mask value, all lines rise together
    for (int m = 0; m < 256; m++) begin
      wr_mask(16'(m));
      src = 8'hFF;
      repeat (3) @(negedge clk);
      for (int b = 1; b < 8; b++) begin
        if (m[b]) begin
          chk(valid == 1'b1 && vec == 3'(b), "R7 order", {valid, vec}, 8 + b);
          pulse_ack();
        end
      end
      chk(valid == 1'b0, "R7 drained", valid, 0);
      settle();
    end

    // R4: edge while masked is lost
    wr_mask(16'h00DF);
    src = 8'h20;
    repeat (3) @(negedge clk);
    wr_mask(16'h00FF);
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R4 masked edge lost", valid, 0);
    settle();

    // R8/R9: enable gating and repeated request drop
    ie = 1'b0;
    src = 8'h40;
    repeat (4) @(negedge clk);
    chk(valid == 1'b0, "R8 ie low", valid, 0);
    settle();
    src = 8'h40;
    repeat (4) @(negedge clk);
    src = '0;
    ie = 1'b1;
    @(negedge clk);
    chk(valid == 1'b1 && vec == 3'd6, "R8 held request", {valid, vec}, 14);
    ie = 1'b0;
    @(negedge clk);
    chk(valid == 1'b0, "R8 ie drop", valid, 0);
    ie = 1'b1;
    @(negedge clk);
    chk(valid == 1'b1 && vec == 3'd6, "R8 kept pending", {valid, vec}, 14);
    pulse_ack();
    chk(valid == 1'b0, "R9 single delivery", valid, 0);
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R9 no repeat", valid, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule